// File: doc/BRIEF.md
# Reload-Counter Serial Bit-Rate Generator

This block produces the timing strobes for a pair of byte-oriented serial ports. Each port gets a single-clock strobe at sixteen times its bit rate, which a receiver uses for oversampling. Each port also gets a single-clock strobe at the bit rate itself, which a transmitter uses. Every rate comes from an up-counter that restarts from a programmed start value each time it passes its top count. The resulting overflow pulses then pass through a fixed prescaler.

Channel A has two rate sources. The first is a 10-bit start value split into a 2-bit upper part and an 8-bit lower part, with a prescale of 64 per bit. The second is an 8-bit timer with its own start byte, with a prescale of 384 per bit. A rate-doubling flag halves the prescale on either source. Channel B has its own 10-bit start value and a fixed prescale of 32, and it has no doubling. A common enable starts every counter. When the enable is low, every counter and prescaler is held cleared.

Top module: `baud_gen_top`

## Requirements
- R1: While reset is asserted or `en` is low, none of the four tick outputs is ever high. Dropping `en` clears all counters.
- R2: With `a_src_tmr`=0 and `a_dbl`=0, after the first tick following enable, `a_tick16` pulses every 4×(1024−R) clocks, where R = {`a_rel_hi`,`a_rel_lo`}.
- R3: With `a_dbl`=1, the channel A prescale halves. The internal source gives a `a_tick16` interval of 2×(1024−R). The timer source gives 12×(256−T).
- R4: With `a_src_tmr`=1 and `a_dbl`=0, `a_tick16` pulses every 24×(256−T) clocks, where T = `tmr_rel`.
- R5: `b_tick16` pulses every 2×(1024−S) clocks, where S = {`b_rel_hi`,`b_rel_lo`}. `a_dbl` has no effect on it.
- R6: Each bit tick pulses every 16 of its channel's `tick16` pulses, always in the same cycle as one of them.
- R7: The start value is {hi[1:0], lo[7:0]}, with hi in bits 9:8. R=1023 gives a counter period of 1 clock. R=0 gives a period of 1024 clocks.
- R8: A new start value written mid-period takes effect only at the next overflow. The period in progress runs out with the old value.
- R9: Every tick is high for exactly one clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| en | input | 1 | Run enable for all counters |
| a_rel_hi | input | 2 | Channel A start value bits 9:8 |
| a_rel_lo | input | 8 | Channel A start value bits 7:0 |
| a_dbl | input | 1 | Channel A rate doubling |
| a_src_tmr | input | 1 | Channel A source: 1 = 8-bit timer, 0 = 10-bit counter |
| tmr_rel | input | 8 | Timer start byte |
| b_rel_hi | input | 2 | Channel B start value bits 9:8 |
| b_rel_lo | input | 8 | Channel B start value bits 7:0 |
| a_tick16 | output | 1 | Channel A strobe at 16× bit rate |
| a_bit_tick | output | 1 | Channel A strobe at bit rate |
| b_tick16 | output | 1 | Channel B strobe at 16× bit rate |
| b_bit_tick | output | 1 | Channel B strobe at bit rate |

## Verification
A `tick16` strobe rises one clock after the counter overflow that completes its prescale count. The bit tick rises in that same cycle, on every sixteenth strobe. The first strobe after enable includes an unpredictable warm-up, so the scoreboard only timestamps it. Every later interval between rising strobes, sampled on the falling edge, is compared with the rate formula. For the mid-period write, the bench changes the start value just after a strobe. It then expects one interval made of one old period and one new period, followed by intervals that use only the new value.

// File: rtl/baudgen_pkg.sv
package baudgen_pkg;

  // Oversampling factor between the fast strobe and the bit strobe.
  localparam int OVS = 16;

  // Prescale per bit for each source.
  localparam int A_INT_BASE = 64;
  localparam int A_TMR_BASE = 384;
  localparam int B_INT_BASE = 32;

  // Number of counter overflows per fast strobe, before doubling.
  function automatic int overflows_per_strobe(input int base_per_bit);
    return base_per_bit / OVS;
  endfunction

  // The doubling flag halves the overflow count per strobe.
  function automatic int apply_double(input int ovf_count, input logic dbl);
    return dbl ? (ovf_count >> 1) : ovf_count;
  endfunction

  // Clocks per counter period for a given start value and counter width.
  function automatic int counter_period(input int width, input int start);
    return (1 << width) - start;
  endfunction

endpackage

// File: rtl/bg_reload_ctr.sv
module bg_reload_ctr #(
  parameter int W = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic [W-1:0] start_val,
  output logic [W-1:0] cnt,
  output logic         ovf
);
  localparam logic [W-1:0] TOP = '1;

  logic [W-1:0] cnt_q;

  // The overflow fires in the last cycle of a period.
  assign ovf = en && (cnt_q == TOP);
  assign cnt = cnt_q;

  // The start value is sampled only at overflow, so a mid-period write
  // waits for the running period to finish.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (!en) begin
      cnt_q <= '0;
    end else if (ovf) begin
      cnt_q <= start_val;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/bg_pulse_div.sv
module bg_pulse_div #(
  parameter int CW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic [CW-1:0] div,
  input  logic          in_pulse,
  output logic          fire,
  output logic          tick
);
  logic [CW-1:0] cnt_q;
  logic [CW:0]   next_cnt;

  assign next_cnt = {1'b0, cnt_q} + 1'b1;
  // Fire when this input pulse completes a group of div pulses.
  assign fire = en && in_pulse && (next_cnt >= {1'b0, div});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      tick  <= 1'b0;
    end else if (!en) begin
      cnt_q <= '0;
      tick  <= 1'b0;
    end else begin
      tick <= fire;
      if (fire) begin
        cnt_q <= '0;
      end else if (in_pulse) begin
        cnt_q <= next_cnt[CW-1:0];
      end
    end
  end
endmodule

// File: rtl/baud_gen_top.sv
module baud_gen_top
  import baudgen_pkg::*;
#(
  parameter int REL_W = 10,
  parameter int TMR_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               en,
  input  logic [1:0]         a_rel_hi,
  input  logic [7:0]         a_rel_lo,
  input  logic               a_dbl,
  input  logic               a_src_tmr,
  input  logic [TMR_W-1:0]   tmr_rel,
  input  logic [1:0]         b_rel_hi,
  input  logic [7:0]         b_rel_lo,
  output logic               a_tick16,
  output logic               a_bit_tick,
  output logic               b_tick16,
  output logic               b_bit_tick
);
  localparam int A_INT_DIV = overflows_per_strobe(A_INT_BASE);
  localparam int A_TMR_DIV = overflows_per_strobe(A_TMR_BASE);
  localparam int B_DIV     = overflows_per_strobe(B_INT_BASE);
  localparam int DIV_W     = $clog2(A_TMR_DIV + 1) > $clog2(OVS + 1)
                             ? $clog2(A_TMR_DIV + 1) : $clog2(OVS + 1);
  localparam int NCH       = 2;

  // Named internal events for the checker.
  logic [REL_W-1:0] a_rel, b_rel;
  logic [REL_W-1:0] a_cnt, b_cnt;
  logic [TMR_W-1:0] tmr_cnt;
  logic             a_int_ovf, tmr_ovf, b_ovf, a_src_ovf;
  logic [DIV_W-1:0] a_div;
  logic [NCH-1:0]   fire16, bit_fire, tick16_v, bit_tick_v;

  assign a_rel = {a_rel_hi, a_rel_lo};
  assign b_rel = {b_rel_hi, b_rel_lo};

  bg_reload_ctr #(.W(REL_W)) u_a_ctr (
    .clk(clk), .rst_n(rst_n), .en(en), .start_val(a_rel),
    .cnt(a_cnt), .ovf(a_int_ovf)
  );

  bg_reload_ctr #(.W(TMR_W)) u_tmr_ctr (
    .clk(clk), .rst_n(rst_n), .en(en), .start_val(tmr_rel),
    .cnt(tmr_cnt), .ovf(tmr_ovf)
  );

  bg_reload_ctr #(.W(REL_W)) u_b_ctr (
    .clk(clk), .rst_n(rst_n), .en(en), .start_val(b_rel),
    .cnt(b_cnt), .ovf(b_ovf)
  );

  // Channel A source and prescale selection.
  always_comb begin
    if (a_src_tmr) begin
      a_src_ovf = tmr_ovf;
      a_div     = DIV_W'(apply_double(A_TMR_DIV, a_dbl));
    end else begin
      a_src_ovf = a_int_ovf;
      a_div     = DIV_W'(apply_double(A_INT_DIV, a_dbl));
    end
  end

  bg_pulse_div #(.CW(DIV_W)) u_a_pre (
    .clk(clk), .rst_n(rst_n), .en(en), .div(a_div), .in_pulse(a_src_ovf),
    .fire(fire16[0]), .tick(tick16_v[0])
  );

  bg_pulse_div #(.CW(DIV_W)) u_b_pre (
    .clk(clk), .rst_n(rst_n), .en(en), .div(DIV_W'(B_DIV)), .in_pulse(b_ovf),
    .fire(fire16[1]), .tick(tick16_v[1])
  );

  // Bit-rate dividers, one per channel, fed by the fast-strobe fire.
  for (genvar ch = 0; ch < NCH; ch++) begin : g_bit
    bg_pulse_div #(.CW(DIV_W)) u_bit (
      .clk(clk), .rst_n(rst_n), .en(en), .div(DIV_W'(OVS)),
      .in_pulse(fire16[ch]), .fire(bit_fire[ch]), .tick(bit_tick_v[ch])
    );
  end

  assign a_tick16   = tick16_v[0];
  assign b_tick16   = tick16_v[1];
  assign a_bit_tick = bit_tick_v[0];
  assign b_bit_tick = bit_tick_v[1];
endmodule

module baud_gen_chk #(
  parameter int REL_W = 10,
  parameter int TMR_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             en,
  input logic             a_tick16,
  input logic             a_bit_tick,
  input logic             b_tick16,
  input logic             b_bit_tick,
  input logic             a_int_ovf,
  input logic             a_src_ovf,
  input logic             tmr_ovf,
  input logic [REL_W-1:0] a_cnt,
  input logic [REL_W-1:0] a_rel,
  input logic [TMR_W-1:0] tmr_cnt,
  input logic [TMR_W-1:0] tmr_rel,
  input logic [1:0]       fire16,
  input logic [1:0]       bit_fire
);
  a_r1_quiet_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !(a_tick16 || a_bit_tick || b_tick16 || b_bit_tick));

  a_r8_load_at_ovf: assert property (@(posedge clk) disable iff (!rst_n)
    a_int_ovf |=> a_cnt == $past(a_rel));

  a_r8_step_between: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !a_int_ovf) |=> a_cnt == REL_W'($past(a_cnt) + 1'b1));

  a_r4_tmr_load: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_ovf |=> tmr_cnt == $past(tmr_rel));

  a_r2_tick_follows_ovf: assert property (@(posedge clk) disable iff (!rst_n)
    a_tick16 |-> $past(a_src_ovf));

  a_r6_bit_with_tick_a: assert property (@(posedge clk) disable iff (!rst_n)
    a_bit_tick |-> a_tick16);

  a_r6_bit_with_tick_b: assert property (@(posedge clk) disable iff (!rst_n)
    b_bit_tick |-> b_tick16);

  a_r6_bit_fire_nested: assert property (@(posedge clk) disable iff (!rst_n)
    bit_fire != 2'b00 |-> (bit_fire & ~fire16) == 2'b00);

  a_r9_single_a: assert property (@(posedge clk) disable iff (!rst_n)
    a_tick16 |=> !a_tick16);

  a_r9_single_b: assert property (@(posedge clk) disable iff (!rst_n)
    b_tick16 |=> !b_tick16);
endmodule

bind baud_gen_top baud_gen_chk #(.REL_W(REL_W), .TMR_W(TMR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .en(en),
  .a_tick16(a_tick16), .a_bit_tick(a_bit_tick),
  .b_tick16(b_tick16), .b_bit_tick(b_bit_tick),
  .a_int_ovf(a_int_ovf), .a_src_ovf(a_src_ovf), .tmr_ovf(tmr_ovf),
  .a_cnt(a_cnt), .a_rel(a_rel), .tmr_cnt(tmr_cnt), .tmr_rel(tmr_rel),
  .fire16(fire16), .bit_fire(bit_fire)
);

// File: tb/baud_gen_top_tb.sv
module baud_gen_top_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en = 1'b0;
  logic [1:0] a_rel_hi = '0, b_rel_hi = '0;
  logic [7:0] a_rel_lo = '0, b_rel_lo = '0, tmr_rel = '0;
  logic       a_dbl = 1'b0, a_src_tmr = 1'b0;
  logic       a_tick16, a_bit_tick, b_tick16, b_bit_tick;

  always #2 clk = ~clk;  // 250 MHz

  baud_gen_top u_dut (
    .clk(clk), .rst_n(rst_n), .en(en),
    .a_rel_hi(a_rel_hi), .a_rel_lo(a_rel_lo), .a_dbl(a_dbl),
    .a_src_tmr(a_src_tmr), .tmr_rel(tmr_rel),
    .b_rel_hi(b_rel_hi), .b_rel_lo(b_rel_lo),
    .a_tick16(a_tick16), .a_bit_tick(a_bit_tick),
    .b_tick16(b_tick16), .b_bit_tick(b_bit_tick)
  );

  int n_checks = 0, n_fail = 0, cyc = 0, stray = 0;
  bit mon_on = 0, done = 0;
  int q_a16[$], q_abit[$], q_b16[$], q_bbit[$];
  int last_t[4];
  bit have[4];
  string tag[4];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Monitor: timestamp each strobe and compare intervals with the queue.
  task automatic step(input int ch);
    int iv, e;
    if (have[ch]) begin
      iv = cyc - last_t[ch];
      case (ch)
        0: if (q_a16.size()  > 0) begin e = q_a16.pop_front();  check(iv == e, tag[0], iv, e); end
        1: if (q_abit.size() > 0) begin e = q_abit.pop_front(); check(iv == e, tag[1], iv, e); end
        2: if (q_b16.size()  > 0) begin e = q_b16.pop_front();  check(iv == e, tag[2], iv, e); end
        default: if (q_bbit.size() > 0) begin e = q_bbit.pop_front(); check(iv == e, tag[3], iv, e); end
      endcase
    end
    last_t[ch] = cyc;
    have[ch] = 1;
  endtask

  always @(negedge clk) begin
    if (!rst_n || !en) begin
      if (a_tick16 || a_bit_tick || b_tick16 || b_bit_tick) stray++;
    end
    if (mon_on) begin
      if (a_tick16)   step(0);
      if (a_bit_tick) step(1);
      if (b_tick16)   step(2);
      if (b_bit_tick) step(3);
    end
  end

  // Expected intervals, restated from the rate formulas.
  function automatic int a_int_iv(input int r, input bit d);
    return (64 * (1024 - r) / 16) >> d;
  endfunction
  function automatic int a_tmr_iv(input int t, input bit d);
    return (384 * (256 - t) / 16) >> d;
  endfunction
  function automatic int b_iv(input int s);
    return 32 * (1024 - s) / 16;
  endfunction

  task automatic wait_drain();
    while (q_a16.size() + q_abit.size() + q_b16.size() + q_bbit.size() > 0)
      @(negedge clk);
  endtask

  // Driver: configure, push expectations, enable, wait for the scoreboard.
  task automatic run_cfg(input bit tmr, input bit d, input int ra, input int t,
                         input int rb, input int n16, input int nbit,
                         input string ta, input string tb_);
    int ia, ib;
    @(negedge clk);
    en = 0; mon_on = 0;
    repeat (3) @(negedge clk);
    a_src_tmr = tmr; a_dbl = d;
    a_rel_hi = 2'(ra >> 8); a_rel_lo = 8'(ra);
    tmr_rel = 8'(t);
    b_rel_hi = 2'(rb >> 8); b_rel_lo = 8'(rb);
    q_a16.delete(); q_abit.delete(); q_b16.delete(); q_bbit.delete();
    for (int i = 0; i < 4; i++) have[i] = 0;
    tag[0] = ta; tag[1] = {ta, " R6"}; tag[2] = tb_; tag[3] = {tb_, " R6"};
    ia = tmr ? a_tmr_iv(t, d) : a_int_iv(ra, d);
    ib = b_iv(rb);
    for (int i = 0; i < n16; i++) begin q_a16.push_back(ia); q_b16.push_back(ib); end
    for (int i = 0; i < nbit; i++) begin q_abit.push_back(16 * ia); q_bbit.push_back(16 * ib); end
    mon_on = 1;
    en = 1;
    wait_drain();
    mon_on = 0;
  endtask

  initial begin
    repeat (10) @(negedge clk);
    check(!(a_tick16 || a_bit_tick || b_tick16 || b_bit_tick), "R1 reset", 1, 0);
    rst_n = 1;
    repeat (2000) @(negedge clk);
    check(stray == 0, "R1 disabled", stray, 0);

    // Channel A internal, no doubling; channel B at start 1000 (0x3E8).
    run_cfg(0, 0, 1000, 0, 1000, 4, 2, "R2", "R5");
    // Doubling on channel A; channel B must not change (R5).
    run_cfg(0, 1, 990, 0, 1000, 4, 2, "R3", "R5 no-doubling");
    // Timer source, no doubling.
    run_cfg(1, 0, 0, 250, 700, 4, 2, "R4", "R5");
    // Timer source with doubling; T=255 gives a 1-clock timer period.
    run_cfg(1, 1, 0, 255, 1023, 4, 2, "R3 timer", "R7 R9");
    // Highest start value, doubling: interval 2, one-clock pulses.
    run_cfg(0, 1, 1023, 0, 512, 4, 2, "R7 R9", "R7");
    // Start value zero: full 1024-clock counter period.
    run_cfg(0, 0, 0, 0, 512, 3, 0, "R7 zero", "R7");

    // R8: write a new channel B start value right after a strobe.
    @(negedge clk);
    en = 0; mon_on = 0;
    repeat (3) @(negedge clk);
    b_rel_hi = 2'd3; b_rel_lo = 8'hE8;  // 1000
    en = 1;
    begin
      int seen = 0;
      while (seen < 3) begin
        @(negedge clk);
        if (b_tick16) seen++;
      end
    end
    #1;
    b_rel_lo = 8'hF2;  // 1010
    q_a16.delete(); q_abit.delete(); q_bbit.delete(); q_b16.delete();
    for (int i = 0; i < 4; i++) have[i] = 0;
    tag[2] = "R8";
    q_b16.push_back((1024 - 1000) + (1024 - 1010));
    q_b16.push_back(b_iv(1010));
    q_b16.push_back(b_iv(1010));
    last_t[2] = cyc; have[2] = 1;
    mon_on = 1;
    wait_drain();
    mon_on = 0;

    // R1: dropping enable silences all strobes.
    en = 0;
    stray = 0;
    repeat (500) @(negedge clk);
    check(stray == 0, "R1 re-disabled", stray, 0);

    done = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule